// File: doc/BRIEF.md
# Tabular Q-Learning Update Engine

This engine runs tabular Q-learning over a small grid of precision settings. Each state stands for a bucket of operand bit widths, from a 1-bit width at the first state up to a 64-bit width at the last. Each action picks exactly one input of an external design under test to be re-randomized, while every other input keeps its value. The engine holds the Q-table as signed Q8.8 values. It picks an action by an epsilon-greedy rule, then waits while the surrounding environment runs the test and scores it. The environment returns a reward together with the index of the next state. The engine then folds that reward into the table and moves on.

A run is opened by a start command. The command clears the table, places the engine in the first state, zeroes the iteration count and loads epsilon. The run closes when an update reports the last state as the next state, or when the iteration count reaches its cap. The engine is sequenced by one state machine with these states: IDLE, CLEAR, ROW_SCAN (search the current row for its maximum, one entry per cycle), DECIDE (explore or exploit), WAIT_REWARD (action presented, handshake open), NEXT_SCAN (search the next-state row for its maximum), WRITE_BACK (write the new value, decay epsilon, test for termination) and DONE.

The transitions are:
- IDLE to CLEAR on start.
- CLEAR to ROW_SCAN.
- ROW_SCAN to DECIDE after the last column.
- DECIDE to WAIT_REWARD.
- WAIT_REWARD to CLEAR on start, otherwise to NEXT_SCAN on a valid reward.
- NEXT_SCAN to WRITE_BACK after the last column.
- WRITE_BACK to DONE on termination, otherwise back to ROW_SCAN.
- DONE to CLEAR on start.

Top module: `qlearn_engine`

## Requirements
- R1: A start command is taken only when busy_o is low (IDLE, WAIT_REWARD or DONE). It zeroes every Q entry and the iteration count, sets state_o to 0 and loads eps_o from eps_start_i. A start that arrives while busy_o is high has no effect.
- R2: width_o reports the width of the current state as follows. State 0 gives 1 and state N_STATES-1 gives 64. An intermediate state k gives 2 + floor((k-1)*62/(N_STATES-2)), so with four states the values are 1, 2, 33 and 64.
- R3: While action_valid_o is high, rand_mask_o has exactly one bit set, at position action_o. At all other times rand_mask_o is zero.
- R4: When the random byte (bits 15:8 of a 16-bit LFSR) is not below eps_o, the chosen action holds the largest Q value in the current state's row. With eps_o at 0 the choice is always greedy.
- R5: Among equal row maxima the greedy choice is taken at random. The row is scanned from a random starting column and the first maximum found is kept, so repeated choices over an all-zero row do not all return one action.
- R6: In plain mode (blend_i=0) the entry of the current state and action becomes sat16(R + floor(M*gamma_i/256)). Here R is the signed reward, M is the largest entry in the next-state row, and sat16 clamps to the range -32768 to 32767.
- R7: In blend mode (blend_i=1) the entry becomes sat16(Q + floor(alpha_i*(T-Q)/256)). Here T is the plain-mode result and Q is the old entry. With alpha_i equal to 256 this equals plain mode.
- R8: A reward is accepted only in WAIT_REWARD, on a cycle where reward_valid_i is high. reward_valid_i pulses while busy_o is high are ignored.
- R9: If the accepted next state is N_STATES-1, the engine enters DONE with hit_target_o high and the iteration count unchanged.
- R10: If the next state is not N_STATES-1, the iteration count rises by one. When it reaches ITER_LIMIT the engine enters DONE with hit_target_o low.
- R11: Every write-back sets eps_o to eps_o - eps_step_i if that value is at least eps_floor_i. Otherwise eps_o is set to eps_floor_i.
- R12: q_upd_valid_o pulses for exactly one cycle, N_ACTIONS+1 clock edges after the edge that accepts the reward. q_upd_o carries the written value. If the run continues, action_valid_o rises 2*N_ACTIONS+2 edges after that acceptance edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a new run |
| gamma_i | input | 8 | Discount factor, value/256 |
| alpha_i | input | 9 | Blend rate, value/256 (256 = 1.0) |
| blend_i | input | 1 | 1 selects the alpha-blended update |
| eps_start_i | input | 8 | Epsilon loaded on start, value/256 |
| eps_step_i | input | 8 | Epsilon decrement per update |
| eps_floor_i | input | 8 | Lowest epsilon reached by decay |
| reward_i | input | 16 | Signed Q8.8 reward |
| reward_valid_i | input | 1 | Reward and next state are valid |
| next_state_i | input | SW | Next state index (below N_STATES) |
| action_o | output | AW | Chosen action |
| action_valid_o | output | 1 | Action presented; reward awaited |
| rand_mask_o | output | N_ACTIONS | One-hot mask of the input to re-randomize |
| state_o | output | SW | Current state |
| width_o | output | 7 | Bit width of the current state |
| busy_o | output | 1 | Engine working; start and reward ignored |
| done_o | output | 1 | Run finished |
| hit_target_o | output | 1 | Run finished on the target state |
| iter_o | output | CW | Iteration count |
| eps_o | output | 8 | Current epsilon |
| q_upd_o | output | 16 | Value written by the last update |
| q_upd_valid_o | output | 1 | One-cycle pulse with each write-back |

## Verification
Each reward is driven on a falling edge and taken at the next rising edge. From that edge the bench counts falling edges. The update pulse must appear on the (N_ACTIONS+2)-th falling edge and the next action on the (2*N_ACTIONS+3)-th, so both latencies are checked exactly rather than by waiting. The update value, epsilon, iteration count and the done flags are sampled at the falling edge that shows the pulse, because all of them are written on the same WRITE_BACK edge. The greedy choice is checked against the bench's own copy of the table at the falling edge where action_valid_o first shows high.

// File: rtl/qlearn_pkg.sv
package qlearn_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_ROW_SCAN,
        ST_DECIDE,
        ST_WAIT_REWARD,
        ST_NEXT_SCAN,
        ST_WRITE_BACK,
        ST_DONE
    } eng_state_t;

    // Lowest bit width covered by state k of n buckets.
    function automatic int bucket_width(input int k, input int n);
        if (k == 0) return 1;
        if (k == n - 1) return 64;
        return 2 + ((k - 1) * 62) / (n - 2);
    endfunction

endpackage

// File: rtl/qlearn_lfsr.sv
module qlearn_lfsr #(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [15:0] value
);
    // Galois form, taps 16,14,13,11
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            value <= SEED;
        else if (value[0])
            value <= (value >> 1) ^ 16'hB400;
        else
            value <= value >> 1;
    end
endmodule

// File: rtl/qlearn_table.sv
module qlearn_table #(
    parameter int DEPTH = 16,
    parameter int IW    = 4,
    parameter int QW    = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 we,
    input  logic [IW-1:0]        wr_idx,
    input  logic signed [QW-1:0] wr_data,
    input  logic [IW-1:0]        rd_a_idx,
    output logic signed [QW-1:0] rd_a_data,
    input  logic [IW-1:0]        rd_b_idx,
    output logic signed [QW-1:0] rd_b_data
);
    logic signed [QW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (clr) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_a_data = mem[rd_a_idx];
    assign rd_b_data = mem[rd_b_idx];
endmodule

// File: rtl/qlearn_update.sv
module qlearn_update #(
    parameter int QW   = 16,
    parameter int FRAC = 8
) (
    input  logic signed [QW-1:0] reward,
    input  logic signed [QW-1:0] next_max,
    input  logic signed [QW-1:0] q_old,
    input  logic [7:0]           gamma,
    input  logic [8:0]           alpha,
    input  logic                 blend,
    output logic signed [QW-1:0] q_new
);
    localparam int PW = QW + 12;
    localparam logic signed [PW-1:0] QMAX = (PW'(1) <<< (QW - 1)) - PW'(1);
    localparam logic signed [PW-1:0] QMIN = -QMAX - PW'(1);

    logic signed [PW-1:0] r_ext, m_ext, q_ext, g_ext, a_ext;
    logic signed [PW-1:0] disc_prod, tgt_wide, tgt_sat, diff, mix_prod, mix_wide;

    function automatic logic signed [PW-1:0] clamp(input logic signed [PW-1:0] v);
        if (v > QMAX) return QMAX;
        if (v < QMIN) return QMIN;
        return v;
    endfunction

    always_comb begin
        r_ext     = {{(PW-QW){reward[QW-1]}}, reward};
        m_ext     = {{(PW-QW){next_max[QW-1]}}, next_max};
        q_ext     = {{(PW-QW){q_old[QW-1]}}, q_old};
        g_ext     = {{(PW-8){1'b0}}, gamma};
        a_ext     = {{(PW-9){1'b0}}, alpha};
        disc_prod = m_ext * g_ext;
        tgt_wide  = r_ext + (disc_prod >>> FRAC);
        tgt_sat   = clamp(tgt_wide);
        diff      = tgt_sat - q_ext;
        mix_prod  = diff * a_ext;
        mix_wide  = clamp(q_ext + (mix_prod >>> FRAC));
        q_new     = blend ? mix_wide[QW-1:0] : tgt_sat[QW-1:0];
    end
endmodule

// File: rtl/qlearn_engine.sv
module qlearn_engine #(
    parameter int N_STATES   = 4,
    parameter int N_ACTIONS  = 4,
    parameter int ITER_LIMIT = 20,
    parameter int QW         = 16,
    parameter int FRAC       = 8,
    localparam int SW = (N_STATES  > 1) ? $clog2(N_STATES)  : 1,
    localparam int AW = (N_ACTIONS > 1) ? $clog2(N_ACTIONS) : 1,
    localparam int CW = $clog2(ITER_LIMIT + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [7:0]           gamma_i,
    input  logic [8:0]           alpha_i,
    input  logic                 blend_i,
    input  logic [7:0]           eps_start_i,
    input  logic [7:0]           eps_step_i,
    input  logic [7:0]           eps_floor_i,
    input  logic signed [QW-1:0] reward_i,
    input  logic                 reward_valid_i,
    input  logic [SW-1:0]        next_state_i,
    output logic [AW-1:0]        action_o,
    output logic                 action_valid_o,
    output logic [N_ACTIONS-1:0] rand_mask_o,
    output logic [SW-1:0]        state_o,
    output logic [6:0]           width_o,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 hit_target_o,
    output logic [CW-1:0]        iter_o,
    output logic [7:0]           eps_o,
    output logic signed [QW-1:0] q_upd_o,
    output logic                 q_upd_valid_o
);
    import qlearn_pkg::*;

    localparam int DEPTH = N_STATES * N_ACTIONS;
    localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    eng_state_t st_q, st_nx;

    logic [AW-1:0]        idx_q, offset_q, best_act_q, act_q;
    logic signed [QW-1:0] best_val_q, reward_q;
    logic [SW-1:0]        cur_s_q, nxt_s_q;
    logic [CW-1:0]        iter_q;
    logic [7:0]           eps_q;
    logic                 hit_q;
    logic signed [QW-1:0] q_upd_q;
    logic                 q_upd_v_q;

    logic [15:0]          lfsr_v;
    logic [AW-1:0]        rnd_act;
    logic                 last_col, explore, terminate, take_start, take_reward;
    logic [AW:0]          pos_sum;
    logic [AW-1:0]        pos;
    logic [SW-1:0]        scan_row;
    logic [IW-1:0]        rd_a_idx, rd_b_idx;
    logic signed [QW-1:0] rd_a_data, rd_b_data, q_new;
    logic                 tbl_clr, tbl_we;
    logic [6:0]           wtab [N_STATES];

    qlearn_lfsr #(.SEED(16'hACE1)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .value(lfsr_v)
    );

    qlearn_table #(.DEPTH(DEPTH), .IW(IW), .QW(QW)) u_table (
        .clk(clk), .rst_n(rst_n), .clr(tbl_clr), .we(tbl_we),
        .wr_idx(rd_b_idx), .wr_data(q_new),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data)
    );

    qlearn_update #(.QW(QW), .FRAC(FRAC)) u_update (
        .reward(reward_q), .next_max(best_val_q), .q_old(rd_b_data),
        .gamma(gamma_i), .alpha(alpha_i), .blend(blend_i), .q_new(q_new)
    );

    for (genvar g = 0; g < N_STATES; g++) begin : g_width
        assign wtab[g] = 7'(bucket_width(g, N_STATES));
    end

    // Scan addressing: rotated column within the selected row
    always_comb begin
        rnd_act  = AW'(lfsr_v % 16'(N_ACTIONS));
        pos_sum  = {1'b0, offset_q} + {1'b0, idx_q};
        pos      = (pos_sum >= (AW+1)'(N_ACTIONS)) ?
                   AW'(pos_sum - (AW+1)'(N_ACTIONS)) : pos_sum[AW-1:0];
        scan_row = (st_q == ST_NEXT_SCAN) ? nxt_s_q : cur_s_q;
        rd_a_idx = IW'(int'(scan_row) * N_ACTIONS + int'(pos));
        rd_b_idx = IW'(int'(cur_s_q) * N_ACTIONS + int'(act_q));
        last_col = (idx_q == AW'(N_ACTIONS - 1));
        explore  = (lfsr_v[15:8] < eps_q);
        terminate = (nxt_s_q == SW'(N_STATES - 1)) ||
                    (iter_q + CW'(1) == CW'(ITER_LIMIT));
        take_start  = start_i && (st_q == ST_IDLE || st_q == ST_WAIT_REWARD ||
                                  st_q == ST_DONE);
        take_reward = !take_start && reward_valid_i && (st_q == ST_WAIT_REWARD);
        tbl_clr  = (st_q == ST_CLEAR);
        tbl_we   = (st_q == ST_WRITE_BACK);
    end

    // Next-state logic
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE:        if (take_start) st_nx = ST_CLEAR;
            ST_CLEAR:       st_nx = ST_ROW_SCAN;
            ST_ROW_SCAN:    if (last_col) st_nx = ST_DECIDE;
            ST_DECIDE:      st_nx = ST_WAIT_REWARD;
            ST_WAIT_REWARD: if (take_start) st_nx = ST_CLEAR;
                            else if (take_reward) st_nx = ST_NEXT_SCAN;
            ST_NEXT_SCAN:   if (last_col) st_nx = ST_WRITE_BACK;
            ST_WRITE_BACK:  st_nx = terminate ? ST_DONE : ST_ROW_SCAN;
            ST_DONE:        if (take_start) st_nx = ST_CLEAR;
            default:        st_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nx;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q      <= '0;
            offset_q   <= '0;
            best_act_q <= '0;
            act_q      <= '0;
            best_val_q <= '0;
            reward_q   <= '0;
            cur_s_q    <= '0;
            nxt_s_q    <= '0;
            iter_q     <= '0;
            eps_q      <= '0;
            hit_q      <= 1'b0;
            q_upd_q    <= '0;
            q_upd_v_q  <= 1'b0;
        end else begin
            q_upd_v_q <= 1'b0;
            unique case (st_q)
                ST_CLEAR: begin
                    cur_s_q  <= '0;
                    iter_q   <= '0;
                    eps_q    <= eps_start_i;
                    hit_q    <= 1'b0;
                    idx_q    <= '0;
                    offset_q <= rnd_act;
                end
                ST_ROW_SCAN, ST_NEXT_SCAN: begin
                    if (idx_q == '0 || rd_a_data > best_val_q) begin
                        best_val_q <= rd_a_data;
                        best_act_q <= pos;
                    end
                    idx_q <= last_col ? '0 : idx_q + AW'(1);
                end
                ST_DECIDE: begin
                    act_q <= explore ? rnd_act : best_act_q;
                end
                ST_WAIT_REWARD: begin
                    if (take_reward) begin
                        reward_q <= reward_i;
                        nxt_s_q  <= next_state_i;
                        idx_q    <= '0;
                    end
                end
                ST_WRITE_BACK: begin
                    q_upd_q   <= q_new;
                    q_upd_v_q <= 1'b1;
                    if (eps_q >= eps_step_i && (eps_q - eps_step_i) >= eps_floor_i)
                        eps_q <= eps_q - eps_step_i;
                    else
                        eps_q <= eps_floor_i;
                    if (nxt_s_q == SW'(N_STATES - 1)) begin
                        hit_q <= 1'b1;
                    end else begin
                        iter_q  <= iter_q + CW'(1);
                        cur_s_q <= nxt_s_q;
                    end
                    idx_q    <= '0;
                    offset_q <= rnd_act;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy_o         = 1'b1;
        action_valid_o = 1'b0;
        done_o         = 1'b0;
        unique case (st_q)
            ST_IDLE:        busy_o = 1'b0;
            ST_WAIT_REWARD: begin busy_o = 1'b0; action_valid_o = 1'b1; end
            ST_DONE:        begin busy_o = 1'b0; done_o = 1'b1; end
            default:        busy_o = 1'b1;
        endcase
        rand_mask_o   = action_valid_o ? (N_ACTIONS'(1) << act_q) : '0;
        action_o      = act_q;
        state_o       = cur_s_q;
        width_o       = wtab[cur_s_q];
        hit_target_o  = hit_q;
        iter_o        = iter_q;
        eps_o         = eps_q;
        q_upd_o       = q_upd_q;
        q_upd_valid_o = q_upd_v_q;
    end
endmodule

// File: rtl/qlearn_engine_chk.sv
module qlearn_engine_chk #(
    parameter int N_ACTIONS  = 4,
    parameter int ITER_LIMIT = 20,
    parameter int SW = 2,
    parameter int AW = 2,
    parameter int CW = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start_i,
    input logic                 busy_o,
    input logic                 action_valid_o,
    input logic                 done_o,
    input logic                 hit_target_o,
    input logic [AW-1:0]        action_o,
    input logic [N_ACTIONS-1:0] rand_mask_o,
    input logic                 q_upd_valid_o,
    input logic [CW-1:0]        iter_o,
    input logic [SW-1:0]        state_o
);
    assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o ##1 (iter_o == '0 && state_o == '0));

    assert_mask_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        action_valid_o |-> ($countones(rand_mask_o) == 1 && rand_mask_o[action_o]));

    assert_mask_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !action_valid_o |-> (rand_mask_o == '0));

    assert_update_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q_upd_valid_o |-> $past(busy_o));

    assert_busy_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (!action_valid_o && !done_o));

    assert_target_keeps_iter_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q_upd_valid_o && hit_target_o) |-> (done_o && $stable(iter_o)));

    assert_done_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    assert_iter_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q_upd_valid_o && !hit_target_o) |-> (iter_o == CW'($past(iter_o) + 1'b1)));

    assert_iter_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        iter_o <= CW'(ITER_LIMIT));

    assert_pulse_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        q_upd_valid_o |=> !q_upd_valid_o);
endmodule

bind qlearn_engine qlearn_engine_chk #(
    .N_ACTIONS(N_ACTIONS), .ITER_LIMIT(ITER_LIMIT), .SW(SW), .AW(AW), .CW(CW)
) i_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
    .action_valid_o(action_valid_o), .done_o(done_o), .hit_target_o(hit_target_o),
    .action_o(action_o), .rand_mask_o(rand_mask_o), .q_upd_valid_o(q_upd_valid_o),
    .iter_o(iter_o), .state_o(state_o)
);

// File: tb/test_qlearn_engine.sv
module test_qlearn_engine;
    localparam int NS = 4;
    localparam int NA = 4;
    localparam int LIM = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [7:0] gamma_i = '0;
    logic [8:0] alpha_i = '0;
    logic blend_i = 1'b0;
    logic [7:0] eps_start_i = '0, eps_step_i = '0, eps_floor_i = '0;
    logic signed [15:0] reward_i = '0;
    logic reward_valid_i = 1'b0;
    logic [1:0] next_state_i = '0;
    logic [1:0] action_o;
    logic action_valid_o;
    logic [NA-1:0] rand_mask_o;
    logic [1:0] state_o;
    logic [6:0] width_o;
    logic busy_o, done_o, hit_target_o, q_upd_valid_o;
    logic [4:0] iter_o;
    logic [7:0] eps_o;
    logic signed [15:0] q_upd_o;

    int checks = 0;
    int errors = 0;
    int qm [NS][NA];
    int cur_m, iter_m, eps_m;

    always #2 clk = ~clk;

    qlearn_engine #(.N_STATES(NS), .N_ACTIONS(NA), .ITER_LIMIT(LIM)) i_qlearn_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .gamma_i(gamma_i),
        .alpha_i(alpha_i), .blend_i(blend_i), .eps_start_i(eps_start_i),
        .eps_step_i(eps_step_i), .eps_floor_i(eps_floor_i), .reward_i(reward_i),
        .reward_valid_i(reward_valid_i), .next_state_i(next_state_i),
        .action_o(action_o), .action_valid_o(action_valid_o), .rand_mask_o(rand_mask_o),
        .state_o(state_o), .width_o(width_o), .busy_o(busy_o), .done_o(done_o),
        .hit_target_o(hit_target_o), .iter_o(iter_o), .eps_o(eps_o),
        .q_upd_o(q_upd_o), .q_upd_valid_o(q_upd_valid_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sat16(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int exp_width(input int k);
        if (k == 0) return 1;
        if (k == NS - 1) return 64;
        return 2 + ((k - 1) * 62) / (NS - 2);
    endfunction

    task automatic do_start(input int es, input int est, input int efl,
                            input bit bl, input int al, input int g);
        @(negedge clk);
        eps_start_i = 8'(es); eps_step_i = 8'(est); eps_floor_i = 8'(efl);
        blend_i = bl; alpha_i = 9'(al); gamma_i = 8'(g);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int s = 0; s < NS; s++) for (int a = 0; a < NA; a++) qm[s][a] = 0;
        cur_m = 0; iter_m = 0; eps_m = es;
    endtask

    task automatic wait_action();
        int n = 0;
        while (!action_valid_o && n < 300) begin @(negedge clk); n++; end
    endtask

    task automatic step(input int r, input int nxt, input bit poke);
        int a, k, mx, mn, q, t, expq;
        wait_action();
        a = int'(action_o);
        chk(int'(state_o) == cur_m, "R1 state", int'(state_o), cur_m);
        chk(int'(width_o) == exp_width(cur_m), "R2 width", int'(width_o), exp_width(cur_m));
        chk(rand_mask_o == NA'(1 << a), "R3 mask", int'(rand_mask_o), 1 << a);
        if (eps_m == 0) begin
            mx = qm[cur_m][0];
            for (int j = 1; j < NA; j++) if (qm[cur_m][j] > mx) mx = qm[cur_m][j];
            chk(qm[cur_m][a] == mx, "R4 greedy", qm[cur_m][a], mx);
        end
        reward_i = 16'(r); next_state_i = 2'(nxt); reward_valid_i = 1'b1;
        k = 0;
        do begin
            @(negedge clk); k++;
            if (k == 1) reward_valid_i = 1'b0;
            if (poke && k == 2) begin
                reward_valid_i = 1'b1; reward_i = 16'sd1000; next_state_i = 2'(NS - 1);
                start_i = 1'b1;
            end
            if (k == 3) begin reward_valid_i = 1'b0; start_i = 1'b0; end
        end while (!q_upd_valid_o && k < 100);
        chk(k == NA + 2, "R12 update latency", k, NA + 2);
        mn = qm[nxt][0];
        for (int j = 1; j < NA; j++) if (qm[nxt][j] > mn) mn = qm[nxt][j];
        q = qm[cur_m][a];
        t = sat16(r + ((mn * int'(gamma_i)) >>> 8));
        expq = blend_i ? sat16(q + (((t - q) * int'(alpha_i)) >>> 8)) : t;
        chk(int'(q_upd_o) == expq, blend_i ? "R7 blend value" : "R6 plain value",
            int'(q_upd_o), expq);
        qm[cur_m][a] = expq;
        if (eps_m >= int'(eps_step_i) && eps_m - int'(eps_step_i) >= int'(eps_floor_i))
            eps_m = eps_m - int'(eps_step_i);
        else
            eps_m = int'(eps_floor_i);
        chk(int'(eps_o) == eps_m, "R11 epsilon decay", int'(eps_o), eps_m);
        if (nxt == NS - 1) begin
            chk(done_o && hit_target_o, "R9 target done", {done_o, hit_target_o}, 3);
            chk(int'(iter_o) == iter_m, "R9 iter kept", int'(iter_o), iter_m);
        end else begin
            iter_m++;
            chk(int'(iter_o) == iter_m, poke ? "R8 iter after ignored poke" : "R10 iter",
                int'(iter_o), iter_m);
            if (iter_m == LIM) begin
                chk(done_o && !hit_target_o, "R10 cap done", {done_o, hit_target_o}, 2);
            end else begin
                cur_m = nxt;
                chk(!done_o, "R10 still running", int'(done_o), 0);
                while (!action_valid_o && k < 200) begin @(negedge clk); k++; end
                chk(k == 2 * NA + 3, "R12 action latency", k, 2 * NA + 3);
            end
        end
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !done_o && !action_valid_o, "R1 reset idle",
            {busy_o, done_o, action_valid_o}, 0);
        chk(iter_o == '0 && rand_mask_o == '0 && !q_upd_valid_o, "R3 reset quiet",
            int'(rand_mask_o), 0);

        // Plain update, greedy, saturation, target stop
        do_start(0, 0, 0, 1'b0, 256, 230);
        wait_action();
        chk(iter_o == '0 && state_o == '0 && eps_o == '0, "R1 start state",
            int'(iter_o), 0);
        step(256, 1, 0);
        step(-512, 2, 0);
        step(1000, 1, 0);
        step(32767, 1, 0);
        step(-300, 0, 0);
        step(500, 3, 0);

        // Blend update
        do_start(0, 0, 0, 1'b1, 64, 205);
        step(2000, 1, 0);
        step(-1500, 2, 0);
        step(3000, 1, 0);
        step(700, 2, 0);
        step(-32768, 0, 0);
        step(1200, 3, 0);

        // Blend with alpha 1.0 equals plain
        do_start(0, 0, 0, 1'b1, 256, 128);
        step(900, 2, 0);
        step(-400, 1, 0);
        step(100, 3, 0);

        // Iteration cap with busy-time pokes
        do_start(0, 0, 0, 1'b0, 256, 200);
        for (int i = 0; i < LIM; i++) step(37 * i - 200, i % 3, (i == 3 || i == 11));

        // Epsilon decay
        do_start(200, 50, 26, 1'b0, 256, 180);
        chk(1, "R11 start", 0, 0);
        step(100, 1, 0);
        step(200, 2, 0);
        step(300, 1, 0);
        step(400, 2, 0);
        step(500, 3, 0);

        // Random tie breaking over an all-zero row
        seen = 0;
        for (int i = 0; i < 16; i++) begin
            do_start(0, 0, 0, 1'b0, 256, 200);
            wait_action();
            seen |= (1 << int'(action_o));
            repeat (i % 3) @(negedge clk);
        end
        chk($countones(seen) >= 2, "R5 tie spread", $countones(seen), 2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule